// File: doc/BRIEF.md
# Per-Cluster Thread Issue Selector

The block sits in front of one execution cluster and holds, for each of six resident thread slots, the single instruction that slot wants to issue next. Every cycle it decides which of those instructions may go to the execution units. An instruction qualifies when each source register it actually uses is marked full in its own slot's register scoreboard and the function unit class it needs is not busy. Among qualified slots it picks one with no switch penalty. The same slot may win on consecutive cycles, and a different slot may win on the very next cycle.

Slots 0 to 3 run user threads, slot 4 runs the asynchronous event handler and slot 5 runs the synchronous exception handler. Each slot owns a 16-entry full/empty scoreboard. A bit goes empty when a multicycle instruction targeting that register is issued, or when an explicit empty command names it. It goes full again when a result write-back names it, which may also come from another cluster. While the cluster reports an exception caught in the first execution stage, user slots are held and the two handler slots keep running.

Each slot offers its instruction on a valid/ready pair. The slot holds every instruction field stable while `inst_valid_i` is high and its `inst_ready_o` bit is low. The instruction is consumed in the cycle where both are high. `inst_ready_o` is computed combinationally in the same cycle and may depend on `inst_valid_i`. Write-back, empty commands, unit-busy and the stall input are plain control pins that are never back-pressured.

Top module: `slot_issue_picker`

## Requirements
- R1: At most one `inst_ready_o` bit is high in any cycle, and only for a slot whose `inst_valid_i` is high. `issue_valid_o` is high exactly when one bit is high, and `issue_slot_o` then gives that slot number.
- R2: A valid instruction is eligible only when both of these hold:
  - each source whose enable bit is 1 reads a full register in its own slot's scoreboard;
  - the unit class it names (2-bit index into `unit_busy_i`) is not busy.
  A source whose enable bit is 0 is not checked.
- R3: Slot 5 (exception) wins over every other eligible slot, and slot 4 (event) wins over the user slots 0 to 3.
- R4: User slots are served round-robin. After user slot u issues, the search starts at slot (u+1) mod 4. Handler-slot issues leave the order unchanged.
- R5: Whenever any slot is eligible, some slot issues in that same cycle. A single eligible slot can issue on every cycle.
- R6: Issuing an instruction with its multicycle flag set makes its destination register in its slot empty from the next cycle.
- R7: A write-back (`wb_valid_i`, `wb_slot_i`, `wb_reg_i`) makes that register full from the next cycle. In the write-back cycle itself it already counts as full for eligibility in that slot.
- R8: An empty command clears the masked registers of the named slot only (bit i of the mask is register i). If a set and a clear hit the same register in the same cycle, the register ends empty.
- R9: While `exc_stall_i` is high, no user slot issues. Slots 4 and 5 still issue.
- R10: After reset every scoreboard bit is full and the round-robin search starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid_i | input | 6 | Per slot: pending instruction present |
| inst_ready_o | output | 6 | Per slot: instruction taken this cycle |
| inst_srca_i | input | 24 | Per slot 4-bit first source register |
| inst_srca_en_i | input | 6 | Per slot: first source used |
| inst_srcb_i | input | 24 | Per slot 4-bit second source register |
| inst_srcb_en_i | input | 6 | Per slot: second source used |
| inst_dst_i | input | 24 | Per slot 4-bit destination register |
| inst_multi_i | input | 6 | Per slot: multicycle operation |
| inst_unit_i | input | 12 | Per slot 2-bit unit class |
| unit_busy_i | input | 4 | Per unit class: busy this cycle |
| exc_stall_i | input | 1 | Hold user slots |
| wb_valid_i | input | 1 | Result write-back present |
| wb_slot_i | input | 3 | Write-back slot |
| wb_reg_i | input | 4 | Write-back register |
| empty_valid_i | input | 1 | Empty command present |
| empty_slot_i | input | 3 | Empty command slot |
| empty_mask_i | input | 16 | Registers to mark empty |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_slot_o | output | 3 | Slot that issues |

## Verification
Selection is combinational, so `inst_ready_o`, `issue_valid_o` and `issue_slot_o` answer the inputs of the same cycle, including a write-back bypass arriving in that cycle. Each check therefore drives inputs just after a falling edge and samples outputs a quarter period later, before the next rising edge. Scoreboard changes from a multicycle issue, a write-back or an empty command, and the round-robin pointer step, take effect one rising edge later. They are observed by the selection made in the following cycle. A sweep over all 64 valid patterns, with the stall input both low and high, compares every choice against an arithmetic model of the priority and pointer rules.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int unsigned DEF_USER_SLOTS = 4;
  localparam int unsigned DEF_REGS       = 16;
  localparam int unsigned DEF_UNITS      = 4;

  typedef enum logic [1:0] {ROLE_USER, ROLE_EVENT, ROLE_EXC} slot_role_e;

  function automatic slot_role_e role_of(int unsigned slot, int unsigned nuser);
    if (slot < nuser)       return ROLE_USER;
    else if (slot == nuser) return ROLE_EVENT;
    else                    return ROLE_EXC;
  endfunction
endpackage

// File: rtl/sb_bank.sv
// Full/empty bits of one slot; clear dominates set on a collision.
module sb_bank #(
  parameter int unsigned NREG = 16,
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] full_o
);
  logic [NREG-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_en) set_vec[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) full_o <= '1;
    else        full_o <= (full_o | set_vec) & ~clr_mask;
  end
endmodule

// File: rtl/slot_ready.sv
// Eligibility of one slot's pending instruction.
module slot_ready #(
  parameter int unsigned NREG    = 16,
  parameter int unsigned NUNIT   = 4,
  parameter bit          IS_USER = 1'b1,
  localparam int unsigned RW = $clog2(NREG),
  localparam int unsigned UW = $clog2(NUNIT)
) (
  input  logic             valid,
  input  logic [RW-1:0]    srca,
  input  logic             srca_en,
  input  logic [RW-1:0]    srcb,
  input  logic             srcb_en,
  input  logic [UW-1:0]    unit,
  input  logic [NREG-1:0]  full,
  input  logic             wb_hit,
  input  logic [RW-1:0]    wb_idx,
  input  logic [NUNIT-1:0] unit_busy,
  input  logic             stall,
  output logic             elig
);
  logic a_ok, b_ok, held;

  assign a_ok = !srca_en || full[srca] || (wb_hit && (wb_idx == srca));
  assign b_ok = !srcb_en || full[srcb] || (wb_hit && (wb_idx == srcb));
  assign held = IS_USER && stall;
  assign elig = valid && a_ok && b_ok && !unit_busy[unit] && !held;
endmodule

// File: rtl/issue_arb.sv
// Fixed priority for the handler slots, round-robin over user slots.
module issue_arb #(
  parameter int unsigned NUSER = 4,
  localparam int unsigned NS = NUSER + 2,
  localparam int unsigned SW = $clog2(NS),
  localparam int unsigned PW = (NUSER > 1) ? $clog2(NUSER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] elig,
  output logic [NS-1:0] grant,
  output logic          any,
  output logic [SW-1:0] slot
);
  logic [PW-1:0] ptr, ptr_nxt;
  logic          hit;

  always_comb begin
    grant   = '0;
    hit     = 1'b0;
    ptr_nxt = ptr;
    if (elig[NS-1]) begin
      grant[NS-1] = 1'b1;
    end else if (elig[NUSER]) begin
      grant[NUSER] = 1'b1;
    end else begin
      for (int k = 0; k < int'(NUSER); k++) begin
        if (!hit && elig[(int'(ptr) + k) % int'(NUSER)]) begin
          grant[(int'(ptr) + k) % int'(NUSER)] = 1'b1;
          ptr_nxt = PW'((int'(ptr) + k + 1) % int'(NUSER));
          hit     = 1'b1;
        end
      end
    end
  end

  always_comb begin
    slot = '0;
    for (int s = 0; s < int'(NS); s++)
      if (grant[s]) slot = SW'(s);
  end

  assign any = |grant;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (hit) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/slot_issue_picker.sv
module slot_issue_picker
  import issue_pkg::*;
#(
  parameter int unsigned NUSER = DEF_USER_SLOTS,
  parameter int unsigned NREG  = DEF_REGS,
  parameter int unsigned NUNIT = DEF_UNITS,
  localparam int unsigned NS = NUSER + 2,
  localparam int unsigned SW = $clog2(NS),
  localparam int unsigned RW = $clog2(NREG),
  localparam int unsigned UW = $clog2(NUNIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    inst_valid_i,
  output logic [NS-1:0]    inst_ready_o,
  input  logic [NS*RW-1:0] inst_srca_i,
  input  logic [NS-1:0]    inst_srca_en_i,
  input  logic [NS*RW-1:0] inst_srcb_i,
  input  logic [NS-1:0]    inst_srcb_en_i,
  input  logic [NS*RW-1:0] inst_dst_i,
  input  logic [NS-1:0]    inst_multi_i,
  input  logic [NS*UW-1:0] inst_unit_i,
  input  logic [NUNIT-1:0] unit_busy_i,
  input  logic             exc_stall_i,
  input  logic             wb_valid_i,
  input  logic [SW-1:0]    wb_slot_i,
  input  logic [RW-1:0]    wb_reg_i,
  input  logic             empty_valid_i,
  input  logic [SW-1:0]    empty_slot_i,
  input  logic [NREG-1:0]  empty_mask_i,
  output logic             issue_valid_o,
  output logic [SW-1:0]    issue_slot_o
);
  logic [NS-1:0]      elig;
  logic [NS*NREG-1:0] board_flat;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic            wb_hit;
    logic [NREG-1:0] clr_m;
    logic [NREG-1:0] full_v;

    assign wb_hit = wb_valid_i && (wb_slot_i == SW'(s));

    always_comb begin
      clr_m = '0;
      if (empty_valid_i && (empty_slot_i == SW'(s))) clr_m = empty_mask_i;
      if (inst_ready_o[s] && inst_multi_i[s])
        clr_m[inst_dst_i[s*RW +: RW]] = 1'b1;
    end

    sb_bank #(.NREG(NREG)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (wb_hit),
      .set_idx  (wb_reg_i),
      .clr_mask (clr_m),
      .full_o   (full_v)
    );

    slot_ready #(
      .NREG    (NREG),
      .NUNIT   (NUNIT),
      .IS_USER (role_of(s, NUSER) == ROLE_USER)
    ) u_ready (
      .valid     (inst_valid_i[s]),
      .srca      (inst_srca_i[s*RW +: RW]),
      .srca_en   (inst_srca_en_i[s]),
      .srcb      (inst_srcb_i[s*RW +: RW]),
      .srcb_en   (inst_srcb_en_i[s]),
      .unit      (inst_unit_i[s*UW +: UW]),
      .full      (full_v),
      .wb_hit    (wb_hit),
      .wb_idx    (wb_reg_i),
      .unit_busy (unit_busy_i),
      .stall     (exc_stall_i),
      .elig      (elig[s])
    );

    assign board_flat[s*NREG +: NREG] = full_v;
  end

  issue_arb #(.NUSER(NUSER)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .grant (inst_ready_o),
    .any   (issue_valid_o),
    .slot  (issue_slot_o)
  );
endmodule

// File: rtl/slot_issue_picker_chk.sv
module slot_issue_picker_chk #(
  parameter int unsigned NUSER = 4,
  parameter int unsigned NREG  = 16,
  localparam int unsigned NS = NUSER + 2,
  localparam int unsigned SW = $clog2(NS),
  localparam int unsigned RW = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NS-1:0]    inst_valid_i,
  input logic [NS-1:0]    inst_ready_o,
  input logic [NS*RW-1:0] inst_dst_i,
  input logic [NS-1:0]    inst_multi_i,
  input logic             exc_stall_i,
  input logic             wb_valid_i,
  input logic [SW-1:0]    wb_slot_i,
  input logic [RW-1:0]    wb_reg_i,
  input logic             empty_valid_i,
  input logic [SW-1:0]    empty_slot_i,
  input logic [NREG-1:0]  empty_mask_i,
  input logic             issue_valid_o,
  input logic [SW-1:0]    issue_slot_o,
  input logic [NS-1:0]    elig,
  input logic [NS*NREG-1:0] board_flat
);
  logic          cur_multi;
  logic [RW-1:0] cur_dst;
  logic          wb_clean;
  logic          h_mc, h_wb;
  int unsigned   h_mc_idx, h_wb_idx;

  always_comb begin
    cur_multi = 1'b0;
    cur_dst   = '0;
    for (int s = 0; s < int'(NS); s++)
      if (inst_ready_o[s]) begin
        cur_multi = inst_multi_i[s];
        cur_dst   = inst_dst_i[s*RW +: RW];
      end
    wb_clean = wb_valid_i
      && !(empty_valid_i && (empty_slot_i == wb_slot_i) && empty_mask_i[wb_reg_i])
      && !(issue_valid_o && (issue_slot_o == wb_slot_i) && cur_multi && (cur_dst == wb_reg_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_mc <= 1'b0; h_wb <= 1'b0; h_mc_idx <= 0; h_wb_idx <= 0;
    end else begin
      h_mc     <= issue_valid_o && cur_multi;
      h_mc_idx <= int'(issue_slot_o) * NREG + int'(cur_dst);
      h_wb     <= wb_clean;
      h_wb_idx <= int'(wb_slot_i) * NREG + int'(wb_reg_i);
    end
  end

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inst_ready_o) && ((inst_ready_o & ~inst_valid_i) == '0));
  p_flag_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o == (inst_ready_o != '0));
  p_exc_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elig[NS-1] |-> inst_ready_o[NS-1]);
  p_event_over_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (elig[NUSER] && !elig[NS-1]) |-> inst_ready_o[NUSER]);
  p_work_conserving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> issue_valid_o);
  p_multi_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_mc |-> !board_flat[h_mc_idx]);
  p_wb_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    h_wb |-> board_flat[h_wb_idx]);
  p_user_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stall_i |-> (inst_ready_o[NUSER-1:0] == '0));
endmodule

bind slot_issue_picker slot_issue_picker_chk #(.NUSER(NUSER), .NREG(NREG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inst_valid_i  (inst_valid_i),
  .inst_ready_o  (inst_ready_o),
  .inst_dst_i    (inst_dst_i),
  .inst_multi_i  (inst_multi_i),
  .exc_stall_i   (exc_stall_i),
  .wb_valid_i    (wb_valid_i),
  .wb_slot_i     (wb_slot_i),
  .wb_reg_i      (wb_reg_i),
  .empty_valid_i (empty_valid_i),
  .empty_slot_i  (empty_slot_i),
  .empty_mask_i  (empty_mask_i),
  .issue_valid_o (issue_valid_o),
  .issue_slot_o  (issue_slot_o),
  .elig          (elig),
  .board_flat    (board_flat)
);

// File: tb/slot_issue_picker_test.sv
`timescale 1ns/1ps
module slot_issue_picker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  inst_valid_i = '0;
  logic [5:0]  inst_ready_o;
  logic [23:0] inst_srca_i = '0;
  logic [5:0]  inst_srca_en_i = '0;
  logic [23:0] inst_srcb_i = '0;
  logic [5:0]  inst_srcb_en_i = '0;
  logic [23:0] inst_dst_i = '0;
  logic [5:0]  inst_multi_i = '0;
  logic [11:0] inst_unit_i = '0;
  logic [3:0]  unit_busy_i = '0;
  logic        exc_stall_i = 1'b0;
  logic        wb_valid_i = 1'b0;
  logic [2:0]  wb_slot_i = '0;
  logic [3:0]  wb_reg_i = '0;
  logic        empty_valid_i = 1'b0;
  logic [2:0]  empty_slot_i = '0;
  logic [15:0] empty_mask_i = '0;
  logic        issue_valid_o;
  logic [2:0]  issue_slot_o;

  int checks = 0;
  int fails  = 0;
  int ptr    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  slot_issue_picker uut (.*);

  task automatic idle();
    inst_valid_i = '0; inst_srca_en_i = '0; inst_srcb_en_i = '0;
    inst_multi_i = '0; inst_unit_i = '0; unit_busy_i = '0;
    exc_stall_i = 1'b0; wb_valid_i = 1'b0; empty_valid_i = 1'b0;
    empty_mask_i = '0;
  endtask

  task automatic put(int s, int a, bit aen, int b, bit ben, int d, bit mc, int u);
    inst_valid_i[s] = 1'b1;
    inst_srca_i[s*4 +: 4] = 4'(a); inst_srca_en_i[s] = aen;
    inst_srcb_i[s*4 +: 4] = 4'(b); inst_srcb_en_i[s] = ben;
    inst_dst_i[s*4 +: 4]  = 4'(d); inst_multi_i[s]   = mc;
    inst_unit_i[s*2 +: 2] = 2'(u);
  endtask

  // sample a quarter period after the inputs change, before the rising edge
  task automatic chk(string req, logic [5:0] exp);
    logic [2:0] exp_slot;
    #5;
    exp_slot = '0;
    for (int s = 0; s < 6; s++) if (exp[s]) exp_slot = 3'(s);
    checks++;
    if (inst_ready_o !== exp || issue_valid_o !== (exp != 0) ||
        (exp != 0 && issue_slot_o !== exp_slot)) begin
      fails++;
      $display("FAIL %s: ready=%b valid=%b slot=%0d expected ready=%b slot=%0d",
               req, inst_ready_o, issue_valid_o, issue_slot_o, exp, exp_slot);
    end
    for (int u = 0; u < 4; u++) if (exp[u]) ptr = (u + 1) % 4;
  endtask

  function automatic logic [5:0] model(logic [5:0] v, bit st, int p);
    if (v[5]) return 6'b100000;
    if (v[4]) return 6'b010000;
    if (st) return '0;
    for (int k = 0; k < 4; k++)
      if (v[(p + k) % 4]) return 6'(1 << ((p + k) % 4));
    return '0;
  endfunction

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: nothing offered, nothing issued; all registers read as full
    chk("R10", 6'b000000);
    next();
    for (int u = 0; u < 4; u++) put(u, u, 1, 15, 1, 0, 0, 0);
    chk("R10", 6'b000001);
    // R4 / R5: four users ready every cycle rotate and issue back to back
    for (int i = 0; i < 6; i++) begin
      next();
      for (int u = 0; u < 4; u++) put(u, 0, 0, 0, 0, 0, 0, 0);
      chk("R4", model(6'b001111, 0, ptr));
    end
    // R3: handler priority
    next(); for (int s = 0; s < 6; s++) put(s, 0, 0, 0, 0, 0, 0, 0);
    chk("R3", 6'b100000);
    next(); for (int s = 0; s < 5; s++) put(s, 0, 0, 0, 0, 0, 0, 0);
    chk("R3", 6'b010000);
    // R3 / R4 / R9 sweep over every valid pattern with stall low and high
    for (int st = 0; st < 2; st++)
      for (int p = 0; p < 64; p++) begin
        next();
        for (int s = 0; s < 6; s++) if (p[s]) put(s, 0, 0, 0, 0, 0, 0, 0);
        exc_stall_i = st[0];
        chk(st != 0 ? "R9" : "R4", model(6'(p), st != 0, ptr));
      end
    // R9: handler slots run on consecutive cycles while users are held
    for (int i = 0; i < 3; i++) begin
      next(); put(4, 0, 0, 0, 0, 0, 0, 0); put(0, 0, 0, 0, 0, 0, 0, 0);
      exc_stall_i = 1'b1;
      chk("R9", 6'b010000);
    end
    // R6: multicycle issue empties its destination
    next(); put(1, 0, 0, 0, 0, 3, 1, 0);
    chk("R6", 6'b000010);
    next(); put(1, 3, 1, 0, 0, 4, 0, 0);
    chk("R6", 6'b000000);
    // R7: same-cycle write-back bypass, then the bit stays full
    next(); put(1, 3, 1, 0, 0, 4, 0, 0);
    wb_valid_i = 1'b1; wb_slot_i = 3'd1; wb_reg_i = 4'd3;
    chk("R7", 6'b000010);
    next(); put(1, 0, 0, 3, 1, 4, 0, 0);
    chk("R7", 6'b000010);
    // R8: empty command on slot 2 registers 5 and 9
    next(); empty_valid_i = 1'b1; empty_slot_i = 3'd2;
    empty_mask_i = 16'h0220;
    chk("R8", 6'b000000);
    next(); put(2, 9, 1, 0, 0, 0, 0, 0); put(3, 9, 1, 0, 0, 0, 0, 0);
    chk("R8", 6'b001000);
    next(); put(2, 0, 0, 5, 1, 0, 0, 0);
    chk("R8", 6'b000000);
    // R2: a disabled source is not checked
    next(); put(2, 5, 0, 6, 1, 0, 0, 0);
    chk("R2", 6'b000100);
    // R8: clear and set on the same register leave it empty
    next(); empty_valid_i = 1'b1; empty_slot_i = 3'd0; empty_mask_i = 16'h0080;
    wb_valid_i = 1'b1; wb_slot_i = 3'd0; wb_reg_i = 4'd7;
    chk("R8", 6'b000000);
    next(); put(0, 7, 1, 0, 0, 0, 0, 0);
    chk("R8", 6'b000000);
    // R7: write-back to another slot does not help slot 0
    next(); put(0, 7, 1, 0, 0, 0, 0, 0);
    wb_valid_i = 1'b1; wb_slot_i = 3'd1; wb_reg_i = 4'd7;
    chk("R7", 6'b000000);
    next(); put(0, 7, 1, 0, 0, 0, 0, 0);
    wb_valid_i = 1'b1; wb_slot_i = 3'd0; wb_reg_i = 4'd7;
    chk("R7", 6'b000001);
    // R2: busy unit class blocks its instruction only
    next(); put(0, 0, 0, 0, 0, 0, 0, 2); put(1, 0, 0, 0, 0, 0, 0, 1);
    unit_busy_i = 4'b0100;
    chk("R2", 6'b000010);
    next(); put(0, 0, 0, 0, 0, 0, 0, 2); unit_busy_i = 4'b0100;
    chk("R2", 6'b000000);
    next(); put(0, 0, 0, 0, 0, 0, 0, 2);
    chk("R2", 6'b000001);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule